// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This unit lets every core of a clustered multi-core system ring a doorbell on any core, its own included. Each core has one write port, made of an enable, a 3-bit register select and a 32-bit data word. A send can name its target in two ways. It can give a core number within the sender's own cluster. It can also give a core number together with a cluster number.

Each receiving core holds two pending flags: one for doorbells rung by other cores and one for doorbells it rang on itself. It also holds a mask bit for each of these two sources. From these the unit produces one fast-interrupt request per core. Software on a core reads that core's status: a pending bit and an event code that names the source. It clears pending by writing 1 to bit 0 of its status register.

The number of clusters and the number of cores per cluster are parameters. A core's global index is cluster * CORES_PER_CLUSTER + in-cluster number.

Top module: `ipi_doorbell_unit`

## Requirements
- R1: A write with select 0 (local send) sets the "other" pending flag of the core whose in-cluster number is data[7:0], within the sender's own cluster.
- R2: A write with select 1 (global send) sets the pending flag of the core with in-cluster number data[7:0] in cluster data[23:16].
- R3: A send whose target is the sender itself sets the self flag, not the other flag. The event code output reads 1 when the other flag is set, 2 when only the self flag is set, and 0 when neither is set.
- R4: A write with select 2 (status) and data bit 0 = 1 clears both pending flags of the writing core. With data bit 0 = 0 it changes nothing.
- R5: Select 3 sets mask bits and select 4 clears them; data bit 0 addresses the other-source mask and bit 31 the self-source mask. A core's request output is high exactly when some pending flag of that core has its mask bit clear.
- R6: Repeated doorbells are not counted: one status clear removes pending however many sends arrived before it.
- R7: When a doorbell to a core and that core's status clear are registered on the same clock edge, the pending flag ends up set.
- R8: A send naming an in-cluster number at or above CORES_PER_CLUSTER, or a cluster at or above CLUSTERS, changes no state.
- R9: While rst_n is low at a clock edge, all pending flags are cleared and all mask bits are set, so every request output is low.
- R10: A write takes effect on the clock edge that samples it; pending, code and request outputs show the result right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | CLUSTERS*CORES_PER_CLUSTER | Per-core write strobe |
| wr_sel | input | 3*CLUSTERS*CORES_PER_CLUSTER | Per-core register select (0 local send, 1 global send, 2 status, 3 mask set, 4 mask clear) |
| wr_data | input | 32*CLUSTERS*CORES_PER_CLUSTER | Per-core write data |
| irq_o | output | CLUSTERS*CORES_PER_CLUSTER | Per-core fast-interrupt request |
| pend_o | output | CLUSTERS*CORES_PER_CLUSTER | Per-core status bit 0: any doorbell pending |
| code_o | output | 2*CLUSTERS*CORES_PER_CLUSTER | Per-core event code (0 none, 1 other, 2 self) |

## Verification
The assertions assume that each core presents at most one write per cycle, on its own port, and that select values above 4 never carry meaning. The event-code properties also assume that a core's pending flags change only through sends and its own status writes. The stimulus drives each port only through tasks. These tasks apply a single select per core per cycle, with one exception: the same-edge race test raises two ports at once, but on different cores. Out-of-range targets are applied on purpose, so that the decoder's range guard is exercised rather than assumed.

// File: rtl/ipi_pkg.sv
// Shared definitions for the doorbell unit: register selects and event codes.
package ipi_pkg;
    localparam int SEL_W  = 3;
    localparam int DATA_W = 32;
    localparam int FLD_W  = 8;
    localparam int CORE_LSB    = 0;
    localparam int CLUSTER_LSB = 16;
    localparam int MASK_OTHER_BIT = 0;
    localparam int MASK_SELF_BIT  = 31;

    typedef enum logic [SEL_W-1:0] {
        SEL_LOCAL  = 3'd0,
        SEL_GLOBAL = 3'd1,
        SEL_STATUS = 3'd2,
        SEL_MSET   = 3'd3,
        SEL_MCLR   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_OTHER = 2'd1,
        EV_SELF  = 2'd2
    } ev_code_e;
endpackage

// File: rtl/ipi_send_decode.sv
// Target decoder for one sender port.
// Turns a local or global send write into a one-hot target vector over all
// cores. Assumes the sender's own cluster is fixed by SENDER_ID; a target that
// falls outside the configured range produces no bit.
module ipi_send_decode
    import ipi_pkg::*;
#(
    parameter int CLUSTERS          = 2,
    parameter int CORES_PER_CLUSTER = 4,
    parameter int SENDER_ID         = 0,
    localparam int NCORE = CLUSTERS * CORES_PER_CLUSTER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCORE-1:0]  tgt
);
    localparam int OWN_CLUSTER = SENDER_ID / CORES_PER_CLUSTER;

    logic [FLD_W-1:0] core_f;
    logic [FLD_W-1:0] clus_f;
    logic             is_send;

    // Pick the core and cluster fields according to the send flavour.
    always_comb begin
        core_f  = wr_data[CORE_LSB +: FLD_W];
        clus_f  = (wr_sel == SEL_GLOBAL) ? wr_data[CLUSTER_LSB +: FLD_W]
                                         : FLD_W'(OWN_CLUSTER);
        is_send = wr_en && (wr_sel == SEL_LOCAL || wr_sel == SEL_GLOBAL);
    end

    // Raise the single target bit whose cluster and core match the fields.
    always_comb begin
        for (int c = 0; c < CLUSTERS; c++) begin
            for (int k = 0; k < CORES_PER_CLUSTER; k++) begin
                tgt[c*CORES_PER_CLUSTER + k] = is_send &&
                    (int'(clus_f) == c) && (int'(core_f) == k);
            end
        end
    end

    // R8
    range_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_send && (int'(core_f) >= CORES_PER_CLUSTER)) |-> (tgt == '0));

    // R8
    cluster_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_send && (int'(clus_f) >= CLUSTERS)) |-> (tgt == '0));

    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt));
endmodule

// File: rtl/ipi_core_slot.sv
// Receive side of one core: two pending flags, two mask bits, request output.
// Assumes at most one local register write per cycle (set, clear, mask).
// A doorbell arriving on the same edge as a clear takes precedence.
module ipi_core_slot
    import ipi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_other,
    input  logic       ring_self,
    input  logic       clr_wr,
    input  logic       mset_other,
    input  logic       mset_self,
    input  logic       mclr_other,
    input  logic       mclr_self,
    output logic       irq,
    output logic       pend,
    output logic [1:0] code
);
    logic pend_other, pend_self;
    logic mask_other, mask_self;

    // Pending flags: doorbell sets, status clear resets, doorbell wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_other <= 1'b0;
            pend_self  <= 1'b0;
        end else begin
            if (ring_other)      pend_other <= 1'b1;
            else if (clr_wr)     pend_other <= 1'b0;
            if (ring_self)       pend_self  <= 1'b1;
            else if (clr_wr)     pend_self  <= 1'b0;
        end
    end

    // Mask bits: reset to masked, set and clear by explicit writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_other <= 1'b1;
            mask_self  <= 1'b1;
        end else begin
            if (mset_other)      mask_other <= 1'b1;
            else if (mclr_other) mask_other <= 1'b0;
            if (mset_self)       mask_self  <= 1'b1;
            else if (mclr_self)  mask_self  <= 1'b0;
        end
    end

    // Outputs: request gating, status bit and event code.
    always_comb begin
        irq  = (pend_other && !mask_other) || (pend_self && !mask_self);
        pend = pend_other || pend_self;
        if (pend_other)     code = EV_OTHER;
        else if (pend_self) code = EV_SELF;
        else                code = EV_NONE;
    end

    // R7
    ring_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_other || ring_self) |=> pend);

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !ring_other && !ring_self) |=> (!pend && code == EV_NONE));

    // R9
    reset_masked_chk: assert property (@(posedge clk)
        !rst_n |=> !irq);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ring_other || ring_self || mclr_other || mclr_self));

    // R3
    self_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_self && !ring_other && !pend) |=> (code == EV_SELF));
endmodule

// File: rtl/ipi_doorbell_unit.sv
// Top of the inter-processor doorbell unit.
// One decoder per sender builds a target vector; per receiver the diagonal
// entry is a self doorbell and every other sender's bit is a cross-core one.
// Assumes each core drives only its own write port.
module ipi_doorbell_unit
    import ipi_pkg::*;
#(
    parameter int CLUSTERS          = 2,
    parameter int CORES_PER_CLUSTER = 4,
    localparam int NCORE = CLUSTERS * CORES_PER_CLUSTER
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORE-1:0]        wr_en,
    input  logic [NCORE*SEL_W-1:0]  wr_sel,
    input  logic [NCORE*DATA_W-1:0] wr_data,
    output logic [NCORE-1:0]        irq_o,
    output logic [NCORE-1:0]        pend_o,
    output logic [NCORE*2-1:0]      code_o
);
    logic [NCORE-1:0] tgt [NCORE];

    generate
        for (genvar s = 0; s < NCORE; s++) begin : g_send
            ipi_send_decode #(
                .CLUSTERS          (CLUSTERS),
                .CORES_PER_CLUSTER (CORES_PER_CLUSTER),
                .SENDER_ID         (s)
            ) u_dec (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en[s]),
                .wr_sel  (wr_sel[s*SEL_W +: SEL_W]),
                .wr_data (wr_data[s*DATA_W +: DATA_W]),
                .tgt     (tgt[s])
            );
        end

        for (genvar r = 0; r < NCORE; r++) begin : g_recv
            logic             ring_other;
            logic [SEL_W-1:0] sel;
            logic [DATA_W-1:0] dat;

            // Merge doorbells from every sender other than this core.
            always_comb begin
                ring_other = 1'b0;
                for (int s = 0; s < NCORE; s++) begin
                    if (s != r) ring_other = ring_other | tgt[s][r];
                end
                sel = wr_sel[r*SEL_W +: SEL_W];
                dat = wr_data[r*DATA_W +: DATA_W];
            end

            ipi_core_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .ring_other (ring_other),
                .ring_self  (tgt[r][r]),
                .clr_wr     (wr_en[r] && sel == SEL_STATUS && dat[0]),
                .mset_other (wr_en[r] && sel == SEL_MSET && dat[MASK_OTHER_BIT]),
                .mset_self  (wr_en[r] && sel == SEL_MSET && dat[MASK_SELF_BIT]),
                .mclr_other (wr_en[r] && sel == SEL_MCLR && dat[MASK_OTHER_BIT]),
                .mclr_self  (wr_en[r] && sel == SEL_MCLR && dat[MASK_SELF_BIT]),
                .irq        (irq_o[r]),
                .pend       (pend_o[r]),
                .code       (code_o[r*2 +: 2])
            );
        end
    endgenerate

    // R10
    no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(pend_o));
endmodule

// File: tb/ipi_doorbell_unit_tb.sv
module ipi_doorbell_unit_tb;
    localparam int NCL = 2;
    localparam int CPC = 4;
    localparam int NC  = NCL * CPC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     wr_en = '0;
    logic [NC*3-1:0]   wr_sel = '0;
    logic [NC*32-1:0]  wr_data = '0;
    logic [NC-1:0]     irq_o;
    logic [NC-1:0]     pend_o;
    logic [NC*2-1:0]   code_o;

    int n_chk = 0;
    int n_bad = 0;

    ipi_doorbell_unit #(.CLUSTERS(NCL), .CORES_PER_CLUSTER(CPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq_o(irq_o), .pend_o(pend_o), .code_o(code_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one write on one core for one cycle; return at the next falling edge.
    task automatic wr(input int core, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = '0;
        wr_en[core] = 1'b1;
        wr_sel[core*3 +: 3] = sel;
        wr_data[core*32 +: 32] = d;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NC; i++) wr(i, 3'd2, 32'h1);
    endtask

    function automatic logic [1:0] code_of(input int i);
        return code_o[i*2 +: 2];
    endfunction

    task automatic t_reset();
        chk("R9 pend after reset", pend_o, 0);
        chk("R9 irq after reset", irq_o, 0);
        wr(0, 3'd0, 32'd1);
        chk("R9 masked at reset: pend", pend_o, 8'h02);
        chk("R9 masked at reset: irq", irq_o, 0);
        clear_all();
    endtask

    task automatic t_local();
        wr(1, 3'd0, 32'd3);
        chk("R1 R10 local send to core 3", pend_o, 8'h08);
        chk("R3 code other", code_of(3), 1);
        wr(5, 3'd0, 32'd0);
        chk("R1 local send stays in cluster 1", pend_o, 8'h18);
        clear_all();
    endtask

    task automatic t_global();
        wr(0, 3'd1, 32'h0001_0002);
        chk("R2 global send cluster 1 core 2", pend_o, 8'h40);
        wr(7, 3'd1, 32'h0000_0001);
        chk("R2 global send cluster 0 core 1", pend_o, 8'h42);
        clear_all();
    endtask

    task automatic t_self();
        wr(2, 3'd0, 32'd2);
        chk("R3 self doorbell pend", pend_o, 8'h04);
        chk("R3 self code", code_of(2), 2);
        wr(0, 3'd0, 32'd2);
        chk("R3 other takes precedence in code", code_of(2), 1);
        clear_all();
    endtask

    task automatic t_clear();
        wr(1, 3'd0, 32'd0);
        wr(0, 3'd2, 32'h0000_0000);
        chk("R4 status write bit0=0 no effect", pend_o, 8'h01);
        wr(0, 3'd2, 32'h0000_0001);
        chk("R4 status write bit0=1 clears", pend_o, 8'h00);
        chk("R4 code none", code_of(0), 0);
    endtask

    task automatic t_mask();
        wr(0, 3'd0, 32'd3);
        wr(3, 3'd4, 32'h8000_0000);
        chk("R5 self unmask leaves other masked", irq_o, 0);
        wr(3, 3'd4, 32'h0000_0001);
        chk("R5 other unmask raises irq", irq_o, 8'h08);
        wr(3, 3'd3, 32'h0000_0001);
        chk("R5 other mask lowers irq", irq_o, 0);
        wr(7, 3'd0, 32'd3);
        wr(7, 3'd4, 32'h8000_0000);
        chk("R5 self unmask raises irq", irq_o, 8'h80);
        wr(7, 3'd2, 32'h1);
        chk("R5 irq drops on clear", irq_o, 0);
        clear_all();
    endtask

    task automatic t_repeat();
        wr(0, 3'd0, 32'd1);
        wr(2, 3'd0, 32'd1);
        wr(3, 3'd0, 32'd1);
        chk("R6 pending after repeats", pend_o, 8'h02);
        wr(1, 3'd2, 32'h1);
        chk("R6 one clear removes all", pend_o, 8'h00);
    endtask

    task automatic t_race();
        wr(0, 3'd0, 32'd1);
        @(negedge clk);
        wr_en = '0;
        wr_en[0] = 1'b1; wr_sel[0 +: 3] = 3'd0; wr_data[0 +: 32] = 32'd1;
        wr_en[1] = 1'b1; wr_sel[3 +: 3] = 3'd2; wr_data[32 +: 32] = 32'h1;
        @(negedge clk);
        wr_en = '0;
        chk("R7 doorbell beats clear", pend_o, 8'h02);
        clear_all();
    endtask

    task automatic t_range();
        wr(0, 3'd0, 32'd4);
        chk("R8 local core out of range", pend_o, 0);
        wr(0, 3'd1, 32'h0002_0000);
        chk("R8 global cluster out of range", pend_o, 0);
        wr(4, 3'd1, 32'h0001_00FF);
        chk("R8 global core out of range", pend_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_local();
        t_global();
        t_self();
        t_clear();
        t_mask();
        t_repeat();
        t_race();
        t_range();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule